// File: doc/BRIEF.md
# AFSK Tone Modulator

This block turns a stream of bytes into audio-frequency shift keyed samples for an 8-bit unsigned DAC. It takes bytes through a valid/ready handshake and holds one of them. On each pulse of a sample strobe it produces one new DAC sample. Every data bit lasts a fixed number of samples. The tones are built by a phase accumulator that addresses a quarter-wave sine table. A zero bit is sent by switching between the low (1200 Hz) and high (2200 Hz) tone, and a one bit keeps the current tone. The tone switch is therefore the NRZI line code itself.

HDLC zero-bit insertion is applied to ordinary bytes. The flag byte and the abort byte are sent without insertion when they arrive on their own, so that a receiver can recognise them as frame delimiters. A configurable escape code makes the following byte go out as plain data, with insertion applied, whatever its value. Transmission starts by itself when a byte is waiting. It stops at a byte boundary when the next byte has not arrived yet.

Parameter constraint: `SAMPLE_RATE` must be an integer multiple of 1200.

Top module: `afsk_tx`

## Requirements
- R1: After reset, `dac` is 128, `busy` is 0 and `in_ready` is 1.
- R2: Sine mapping. For a 9-bit phase p, let i = p mod 256. If i ≥ 128, i is replaced by 255 − i. Let T(i) = 128 + floor(128·sin(π·i/256)). The sample is T(i) when p < 256 and 255 − T(i) otherwise.
- R3: On every strobe during transmission, the phase first advances by the current tone's increment and the sample is then taken at the new phase. The increment is round(512·f/SAMPLE_RATE): 64 for the low tone and 117 for the high tone at 9600. The phase wraps modulo 512. Each bit period lasts SAMPLE_RATE/1200 strobes, which is 8 by default.
- R4: When transmission starts from idle, the phase is reset to 0, the low tone is selected and the ones counter is cleared.
- R5: Bits are sent least-significant first. A 0 switches the tone and clears the ones counter. A 1 keeps the tone and increments the counter.
- R6: With insertion enabled, once 5 consecutive ones have been sent, an extra bit period with a tone switch is inserted before the next pending bit, and the counter is cleared.
- R7: Insertion is disabled for an unescaped 0x7E (flag) or 0x7F (abort).
- R8: An escape byte (ESC_CODE, default 0x1B) is not transmitted. The byte after it is sent with insertion enabled, and this holds even when that byte is 0x7E, 0x7F or another escape byte.
- R9: At the start of a byte, the ones counter is cleared only if the previous byte was sent with insertion disabled. Otherwise the run of ones carries over into the new byte.
- R10: If no byte is waiting at a byte boundary, the strobe produces no sample, `busy` falls and `dac` keeps its last value.
- R11: An escape with no byte after it does not keep transmission going. It stays pending and applies to the next byte that arrives, and it does not start transmission on its own.
- R12: `in_ready` is low while a data byte is held and waiting to be sent. An escape byte is accepted without occupying the holding register.
- R13: `dac` changes only on a cycle in which `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Byte offered to the modulator |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Byte is accepted when in_valid and in_ready are both high |
| tick | input | 1 | Sample strobe, one clock wide |
| dac | output | 8 | Unsigned DAC sample |
| busy | output | 1 | High while transmitting |

## Verification
Every sample the block produces is compared with a stream that the bench computes from the requirements. The byte patterns are chosen to separate the different effects:
- All-zero and alternating bytes exercise only the tone switching and the sine lookup.
- A 0xFF byte and a 0xF8/0x07 pair show whether a bit is inserted, and whether a run of ones carries across a byte boundary.
- Bare flags and an abort show that insertion is suppressed for delimiters.
- The same values preceded by an escape show that insertion comes back for them, and that an escaped escape is sent as data.
- A trailing escape with no byte after it, followed later by a lone flag, shows that the escape stays pending and applies to the next byte.

// File: rtl/afsk_tx.sv
module afsk_tx #(
  parameter int         SAMPLE_RATE = 9600,
  parameter logic [7:0] ESC_CODE    = 8'h1B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       tick,
  output logic [7:0] dac,
  output logic       busy
);
  localparam int BIT_RATE  = 1200;
  localparam int LOW_HZ    = 1200;
  localparam int HIGH_HZ   = 2200;
  localparam int PH_BITS   = 9;
  localparam int PH_STEPS  = 1 << PH_BITS;
  localparam int QTR       = PH_STEPS / 4;
  localparam int SPB       = SAMPLE_RATE / BIT_RATE;
  localparam int CW        = $clog2(SPB + 1);
  localparam int STUFF_RUN = 5;
  localparam logic [PH_BITS-1:0] LOW_INC  = PH_BITS'((PH_STEPS * LOW_HZ  + SAMPLE_RATE / 2) / SAMPLE_RATE);
  localparam logic [PH_BITS-1:0] HIGH_INC = PH_BITS'((PH_STEPS * HIGH_HZ + SAMPLE_RATE / 2) / SAMPLE_RATE);
  localparam logic [7:0] FLAG  = 8'h7E;
  localparam logic [7:0] ABORT = 8'h7F;

  logic [7:0] sin_rom [QTR];
  for (genvar g = 0; g < QTR; g++) begin : g_rom
    localparam int V = 128 + $rtoi(128.0 * $sin(3.141592653589793 * real'(g) / real'(2 * QTR)));
    assign sin_rom[g] = 8'(V);
  end

  logic [7:0]         hold_q;
  logic               hold_v, hold_lit, esc_p;
  logic               busy_q, tone, stuff_en;
  logic [CW-1:0]      cnt;
  logic [3:0]         nleft, ones;
  logic [7:0]         shreg, dac_q;
  logic [PH_BITS-1:0] phase;

  logic               at_bnd, stop, load, bit_start, insert, send, cur_stuff;
  logic [7:0]         cur_bits;
  logic [3:0]         cur_left, ones_base, n_ones;
  logic               n_tone;
  logic [CW-1:0]      n_cnt;
  logic [PH_BITS-1:0] n_phase;
  logic [6:0]         ridx;
  logic [7:0]         rval, n_dac;
  logic               accept, take_esc;

  assign in_ready = !hold_v;
  assign accept   = in_valid && in_ready;
  assign take_esc = accept && in_data == ESC_CODE && !esc_p;
  assign busy     = busy_q;
  assign dac      = dac_q;

  always_comb begin
    bit_start = cnt == '0;
    at_bnd    = bit_start && nleft == 4'd0;
    stop      = at_bnd && !hold_v;
    load      = at_bnd && hold_v;
    cur_bits  = load ? hold_q : shreg;
    cur_left  = load ? 4'd8 : nleft;
    cur_stuff = load ? (hold_lit || !(hold_q == FLAG || hold_q == ABORT)) : stuff_en;
    ones_base = (load && !stuff_en) ? 4'd0 : ones;
    insert    = bit_start && cur_stuff && ones_base >= 4'(STUFF_RUN);
    send      = bit_start && !insert;
    if (insert)                   n_ones = 4'd0;
    else if (send && cur_bits[0]) n_ones = 4'(ones_base + 4'd1);
    else if (send)                n_ones = 4'd0;
    else                          n_ones = ones_base;
    n_tone  = tone ^ (insert || (send && !cur_bits[0]));
    n_cnt   = (bit_start ? CW'(SPB) : cnt) - CW'(1);
    n_phase = phase + (n_tone ? HIGH_INC : LOW_INC);
    ridx    = n_phase[7] ? ~n_phase[6:0] : n_phase[6:0];
    rval    = sin_rom[ridx];
    n_dac   = n_phase[8] ? 8'd255 - rval : rval;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0; hold_v <= 1'b0; hold_lit <= 1'b0; esc_p <= 1'b0;
      busy_q <= 1'b0; tone <= 1'b0; stuff_en <= 1'b0;
      cnt <= '0; nleft <= '0; ones <= '0; shreg <= '0;
      phase <= '0; dac_q <= 8'd128;
    end else begin
      if (busy_q && tick) begin
        if (stop) begin
          busy_q <= 1'b0;
        end else begin
          if (load) hold_v <= 1'b0;
          shreg    <= send ? cur_bits >> 1 : cur_bits;
          nleft    <= send ? cur_left - 4'd1 : cur_left;
          stuff_en <= cur_stuff;
          ones     <= n_ones;
          tone     <= n_tone;
          cnt      <= n_cnt;
          phase    <= n_phase;
          dac_q    <= n_dac;
        end
      end else if (!busy_q && hold_v) begin
        busy_q <= 1'b1;
        phase  <= '0;
        tone   <= 1'b0;
        ones   <= '0;
        cnt    <= '0;
        nleft  <= '0;
      end
      if (accept) begin
        if (take_esc) begin
          esc_p <= 1'b1;
        end else begin
          hold_q   <= in_data;
          hold_lit <= esc_p;
          hold_v   <= 1'b1;
          esc_p    <= 1'b0;
        end
      end
    end
  end

  assert_dac_only_on_tick_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(dac_q));
  assert_start_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (phase == '0 && !tone && ones == 4'd0));
  assert_stop_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(tick && cnt == '0 && nleft == 4'd0 && !hold_v));
  assert_run_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && stuff_en) |-> ones <= 4'(STUFF_RUN));
  assert_data_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !take_esc) |=> (hold_v && !in_ready));
  assert_bit_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(SPB));
endmodule

// File: tb/tb_afsk_tx.sv
module tb_afsk_tx;
  localparam int CLK_PERIOD = 10;
  localparam int SR         = 9600;
  localparam int SPB        = SR / 1200;
  localparam int TICK_DIV   = 3;
  localparam int LOW_INC    = (512 * 1200 + SR / 2) / SR;
  localparam int HIGH_INC   = (512 * 2200 + SR / 2) / SR;
  localparam logic [7:0] ESC = 8'h1B;
  localparam int NFR = 8;

  typedef logic [7:0] blist_t [4];

  localparam blist_t FRAMES [NFR] = '{
    '{8'h00, 8'h00, 8'h00, 8'h00},
    '{8'hFF, 8'h00, 8'h00, 8'h00},
    '{8'h7E, 8'h7E, 8'h00, 8'h00},
    '{8'h1B, 8'h7E, 8'h55, 8'h00},
    '{8'h7F, 8'hF8, 8'h07, 8'h00},
    '{8'h1B, 8'h1B, 8'hA5, 8'h00},
    '{8'hF8, 8'h7E, 8'h00, 8'h00},
    '{8'hAA, 8'h55, 8'hC3, 8'h3C}
  };
  localparam int FLEN [NFR] = '{1, 2, 2, 3, 3, 3, 2, 4};
  localparam string FTAG [NFR] = '{"R5 zeros", "R6 ones run", "R7 bare flags",
    "R8 escaped flag", "R9 clear after abort", "R8 escaped escape",
    "R9 carry into flag", "R5 mixed"};

  logic clk = 0, rst_n = 0, in_valid = 0, tick = 0;
  logic [7:0] in_data = 0;
  logic in_ready, busy;
  logic [7:0] dac;
  int total = 0, fails = 0, tc = 0;
  bit feed_done;
  int exp_q [$];

  afsk_tx #(.SAMPLE_RATE(SR), .ESC_CODE(ESC)) dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .tick(tick), .dac(dac), .busy(busy));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sine(input int p);
    int i, v;
    i = p % 256;
    if (i >= 128) i = 255 - i;
    v = 128 + $rtoi(128.0 * $sin(3.141592653589793 * real'(i) / 256.0));
    return (p >= 256) ? 255 - v : v;
  endfunction

  task automatic build_exp(input blist_t bl, input int n);
    int ph, ones;
    bit tone, sprev, e, st;
    logic [7:0] b;
    ph = 0; ones = 0; tone = 0; sprev = 1; e = 0;
    exp_q.delete();
    for (int k = 0; k < n; k++) begin
      b = bl[k];
      if (b == ESC && !e) begin
        e = 1;
        continue;
      end
      st = e || !(b == 8'h7E || b == 8'h7F);
      e = 0;
      if (!sprev) ones = 0;
      sprev = st;
      for (int j = 0; j < 8; j++) begin
        if (st && ones >= 5) begin
          ones = 0; tone = !tone;
          for (int s = 0; s < SPB; s++) begin
            ph = (ph + (tone ? HIGH_INC : LOW_INC)) % 512;
            exp_q.push_back(sine(ph));
          end
        end
        if (b[j]) ones++;
        else begin ones = 0; tone = !tone; end
        for (int s = 0; s < SPB; s++) begin
          ph = (ph + (tone ? HIGH_INC : LOW_INC)) % 512;
          exp_q.push_back(sine(ph));
        end
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = b;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic run_frame(input blist_t feed, input int nfeed,
                           input blist_t model, input int nmodel, input string tag);
    int got, cyc;
    bit seen, busy_prev, tick_now;
    build_exp(model, nmodel);
    feed_done = (nfeed == 0);
    fork
      begin
        for (int i = 0; i < nfeed; i++) send_byte(feed[i]);
        feed_done = 1;
      end
    join_none
    got = 0; cyc = 0; seen = 0; busy_prev = busy; tick_now = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (tick_now && busy_prev && busy) begin
        if (got < exp_q.size()) check({tag, " R2 R3 R4 sample"}, int'(dac), exp_q[got]);
        got++;
      end
      if (busy) seen = 1;
      if (seen && !busy && feed_done) break;
      if (cyc > 20000) begin
        check({tag, " frame timeout"}, 0, 1);
        break;
      end
      busy_prev = busy;
      tick_now = (tc == TICK_DIV - 1);
      tick = tick_now;
      tc = (tc + 1) % TICK_DIV;
    end
    tick = 0;
    check({tag, " R10 sample count"}, got, exp_q.size());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] last;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 dac reset", int'(dac), 128);
    check("R1 busy reset", int'(busy), 0);
    check("R1 in_ready reset", int'(in_ready), 1);

    send_byte(8'h00);
    repeat (4) @(negedge clk);
    check("R12 ready low while held", int'(in_ready), 0);
    check("R4 busy after byte", int'(busy), 1);
    check("R13 dac without tick", int'(dac), 128);
    run_frame('{8'h00, 8'h00, 8'h00, 8'h00}, 0, FRAMES[0], 1, "R5 first");

    for (int f = 0; f < NFR; f++) begin
      repeat (5) @(negedge clk);
      run_frame(FRAMES[f], FLEN[f], FRAMES[f], FLEN[f], FTAG[f]);
    end

    repeat (5) @(negedge clk);
    run_frame('{8'h55, ESC, 8'h00, 8'h00}, 2, '{8'h55, 8'h00, 8'h00, 8'h00}, 1, "R11 trailing escape");
    last = dac;
    repeat (20) @(negedge clk);
    check("R11 escape alone stays idle", int'(busy), 0);
    check("R12 escape leaves ready", int'(in_ready), 1);
    check("R10 dac holds after stop", int'(dac), int'(last));
    run_frame('{8'h7E, 8'h00, 8'h00, 8'h00}, 1, '{ESC, 8'h7E, 8'h00, 8'h00}, 2, "R11 pending escape");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule